// File: doc/BRIEF.md
# Burst-of-Two DDR SRAM Command Scheduler

This block sits between a simple request/response host port and a common-I/O static RAM that moves two words per access, one on each half of its clock. The host offers one request at a time with a valid/ready handshake: a burst address, a read/write flag, a two-word write payload and per-byte write enables. The scheduler turns each accepted request into a command slot on the memory pins. It places the write data one memory cycle after its command, which is the late-write rule. It captures the two read words one and a half memory cycles after a read command. It then returns both read words to the host together.

The block runs on a single clock at twice the memory rate. A phase flag, which is also presented to the memory side, marks each tick as the rising half (phase 0) or the falling half (phase 1) of a memory cycle. All timing below is counted in these ticks. Tick A is the tick whose closing edge accepts a request. Tick A+1 is the phase-0 tick in which the command is presented. The data bus is shared. The scheduler drives it only while it presents write words, and it holds back a write that would otherwise overlap read data still coming back.

Top module: `ddrb2_sram_ctrl`

## Requirements
- R1: An accepted request is presented as a command during ticks A+1 (phase 0) and A+2. In that command, memLdN is 0 and memAddr equals the request's burst address. memRw is 1 for a read and 0 for a write.
- R2: For a write, the first word is driven on memDqOut in tick A+3 (phase 0) and the second word in tick A+4 (phase 1). memOe is 1 in both ticks.
- R3: For a read, the first word is sampled from memDqIn in tick A+4 and the second word in tick A+5.
- R4: memBwN is active low, one bit per 8-bit lane. Bit i covers data bits 8i+7..8i. Only lanes whose bit is 0 are written.
- R5: The lower half of reqWdata, reqBe and rspData is the word at 2*address. The upper half is the word at 2*address+1.
- R6: A write whose command would land in the slot right after a read command is held one idle slot: reqReady stays 0 for it, and it is accepted 4 ticks after the read. Any other pair of back-to-back requests is accepted 2 ticks apart.
- R7: memOe is 1 only in write-data ticks. It is never 1 in a tick in which read data is returning.
- R8: A read gives a single one-tick rspValid pulse in tick A+6, with both words on rspData.
- R9: reqReady is 1 only in phase-1 ticks. A request is taken at the edge that closes such a tick when reqValid and reqReady are both 1.
- R10: While rstN is 0: memLdN is 1, memOe is 0, rspValid is 0, reqReady is 0 and memPhase is 0. After reset, memPhase toggles on every clock.
- R11: In a slot with no accepted request, memLdN is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Request can be taken at this edge |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | AW | Burst address |
| reqWdata | input | 2*DW | Write words, first word in the low half |
| reqBe | input | 2*NB | Active-high byte enables, first word in the low half |
| rspValid | output | 1 | Read response pulse |
| rspData | output | 2*DW | Read words, first word in the low half |
| memPhase | output | 1 | 0 = rising half, 1 = falling half |
| memLdN | output | 1 | Active-low command strobe |
| memRw | output | 1 | 1 = read, 0 = write |
| memAddr | output | AW | Burst address to memory |
| memDqOut | output | DW | Write word driven on the shared bus |
| memBwN | output | NB | Active-low byte write enables |
| memOe | output | 1 | Bus drive enable |
| memDqIn | input | DW | Word returned on the shared bus |

## Verification
The hardest case to reach from the ports is a write offered in the very slot after a read command. This is the only case in which the controller must withhold reqReady and leave a command slot empty. The stimulus reaches it by issuing a read and a write in back-to-back driver calls. The bench then checks that the acceptance gap is 4 ticks and that the bus model never sees memOe while a read word is due. The same mix is repeated with overlapping addresses and partial byte enables, so that a stall placed one slot early or late shows up as a bus clash or as wrong read-back data.

// File: rtl/ddrb2_pkg.sv
package ddrb2_pkg;
  typedef struct packed {
    logic accept;       // request taken at this edge
    logic acceptWrite;  // taken request is a write
    logic wrStage;      // move staged write words to the bus stage
    logic wrBeat0;      // first write word on the bus this tick
    logic wrBeat1;      // second write word on the bus this tick
    logic rdCap0;       // first read word valid this tick
    logic rdCap1;       // second read word valid this tick
  } ctlStrobes_t;
endpackage

// File: rtl/ddrb2_ctrl.sv
module ddrb2_ctrl
  import ddrb2_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output logic        phase,
  output ctlStrobes_t strobes
);
  localparam int WR_LEN = 4;  // write data ends at tick A+4
  localparam int RD_LEN = 5;  // read data ends at tick A+5

  logic              phaseQ;
  logic              prevRead;
  logic [WR_LEN-1:0] wrPipe;
  logic [RD_LEN-1:0] rdPipe;
  logic              accept;
  logic              turnStall;

  assign turnStall = prevRead && reqWrite;
  assign reqReady  = phaseQ && !turnStall;
  assign accept    = reqValid && reqReady;
  assign phase     = phaseQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ   <= 1'b0;
      prevRead <= 1'b0;
      wrPipe   <= '0;
      rdPipe   <= '0;
    end else begin
      phaseQ <= ~phaseQ;
      wrPipe <= {wrPipe[WR_LEN-2:0], accept && reqWrite};
      rdPipe <= {rdPipe[RD_LEN-2:0], accept && !reqWrite};
      if (phaseQ) prevRead <= accept && !reqWrite;
    end
  end

  always_comb begin
    strobes.accept      = accept;
    strobes.acceptWrite = reqWrite;
    strobes.wrStage     = wrPipe[1];
    strobes.wrBeat0     = wrPipe[2];
    strobes.wrBeat1     = wrPipe[3];
    strobes.rdCap0      = rdPipe[3];
    strobes.rdCap1      = rdPipe[4];
  end

  // R6: no write is taken in the slot right after a read command
  a_r6_turnaround_gap: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqWrite) |-> !rdPipe[1]);
endmodule

// File: rtl/ddrb2_datapath.sv
module ddrb2_datapath
  import ddrb2_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter int NB = DW / 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobes_t     strobes,
  input  logic            phase,
  input  logic [AW-1:0]   reqAddr,
  input  logic [2*DW-1:0] reqWdata,
  input  logic [2*NB-1:0] reqBe,
  input  logic [DW-1:0]   memDqIn,
  output logic            memLdN,
  output logic            memRw,
  output logic [AW-1:0]   memAddr,
  output logic [DW-1:0]   memDqOut,
  output logic [NB-1:0]   memBwN,
  output logic            memOe,
  output logic            rspValid,
  output logic [2*DW-1:0] rspData
);
  logic [2*DW-1:0] stageData, busData;
  logic [2*NB-1:0] stageBe, busBe;
  logic [DW-1:0]   capLo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memLdN    <= 1'b1;
      memRw     <= 1'b1;
      memAddr   <= '0;
      stageData <= '0;
      stageBe   <= '0;
      busData   <= '0;
      busBe     <= '0;
      capLo     <= '0;
      rspValid  <= 1'b0;
      rspData   <= '0;
    end else begin
      if (phase) memLdN <= !strobes.accept;
      if (strobes.accept) begin
        memRw   <= !strobes.acceptWrite;
        memAddr <= reqAddr;
      end
      if (strobes.accept && strobes.acceptWrite) begin
        stageData <= reqWdata;
        stageBe   <= reqBe;
      end
      if (strobes.wrStage) begin
        busData <= stageData;
        busBe   <= stageBe;
      end
      if (strobes.rdCap0) capLo <= memDqIn;
      rspValid <= strobes.rdCap1;
      if (strobes.rdCap1) rspData <= {memDqIn, capLo};
    end
  end

  always_comb begin
    memOe    = strobes.wrBeat0 || strobes.wrBeat1;
    memDqOut = '0;
    memBwN   = '1;
    if (strobes.wrBeat0) begin
      memDqOut = busData[DW-1:0];
      memBwN   = ~busBe[NB-1:0];
    end else if (strobes.wrBeat1) begin
      memDqOut = busData[2*DW-1:DW];
      memBwN   = ~busBe[2*NB-1:NB];
    end
  end

  // R1: a command starts only in a rising-half tick
  a_r1_cmd_rising: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memLdN) |-> !phase);
  // R2: a first write word is always followed by the second
  a_r2_beat_pair: assert property (@(posedge clk) disable iff (!rstN)
    (memOe && !phase) |=> memOe);
  // R7: never drive the bus while read data returns
  a_r7_no_collision: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdCap0 || strobes.rdCap1) |-> !memOe);
  // R8: response is a single-tick pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
endmodule

// File: rtl/ddrb2_sram_ctrl.sv
module ddrb2_sram_ctrl
  import ddrb2_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16,
  localparam int NB = DW / 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic            reqWrite,
  input  logic [AW-1:0]   reqAddr,
  input  logic [2*DW-1:0] reqWdata,
  input  logic [2*NB-1:0] reqBe,
  output logic            rspValid,
  output logic [2*DW-1:0] rspData,
  output logic            memPhase,
  output logic            memLdN,
  output logic            memRw,
  output logic [AW-1:0]   memAddr,
  output logic [DW-1:0]   memDqOut,
  output logic [NB-1:0]   memBwN,
  output logic            memOe,
  input  logic [DW-1:0]   memDqIn
);
  ctlStrobes_t strobes;
  logic        phase;

  assign memPhase = phase;

  ddrb2_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .phase    (phase),
    .strobes  (strobes)
  );

  ddrb2_datapath #(.AW(AW), .DW(DW), .NB(NB)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .phase    (phase),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqBe    (reqBe),
    .memDqIn  (memDqIn),
    .memLdN   (memLdN),
    .memRw    (memRw),
    .memAddr  (memAddr),
    .memDqOut (memDqOut),
    .memBwN   (memBwN),
    .memOe    (memOe),
    .rspValid (rspValid),
    .rspData  (rspData)
  );
endmodule

// File: tb/ddrb2_sram_ctrl_bench.sv
module ddrb2_sram_ctrl_bench;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int NB = DW / 8;
  localparam int WORDS = 2 ** (AW + 1);

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic            reqReady;
  logic            reqWrite = 1'b0;
  logic [AW-1:0]   reqAddr = '0;
  logic [2*DW-1:0] reqWdata = '0;
  logic [2*NB-1:0] reqBe = '0;
  logic            rspValid;
  logic [2*DW-1:0] rspData;
  logic            memPhase, memLdN, memRw, memOe;
  logic [AW-1:0]   memAddr;
  logic [DW-1:0]   memDqOut;
  logic [NB-1:0]   memBwN;
  logic [DW-1:0]   memDqIn = '0;

  always #2 clk = ~clk;

  ddrb2_sram_ctrl #(.AW(AW), .DW(DW)) u_ddrb2_sram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rspValid(rspValid), .rspData(rspData), .memPhase(memPhase),
    .memLdN(memLdN), .memRw(memRw), .memAddr(memAddr), .memDqOut(memDqOut),
    .memBwN(memBwN), .memOe(memOe), .memDqIn(memDqIn)
  );

  int tk = 0;
  int checks = 0;
  int fails = 0;
  always @(posedge clk) tk <= tk + 1;

  logic [DW-1:0]    mem    [WORDS];
  logic [DW-1:0]    shadow [WORDS];
  logic [AW:0]      cmdExp [int];
  logic [DW+NB-1:0] wrExp  [int];
  int               wrAddrAt [int];
  int               rdAddrAt [int];
  int               rspTickQ [$];
  logic [2*DW-1:0]  rspDataQ [$];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h tick=%0d", req, what, act, exp, tk);
    end
  endtask

  // driver: called just after a falling edge; returns after the next one
  task automatic issue(input bit w, input int a, input logic [2*DW-1:0] d,
                       input logic [2*NB-1:0] be, output int acc);
    int c;
    reqValid = 1'b1; reqWrite = w; reqAddr = a[AW-1:0]; reqWdata = d; reqBe = be;
    #1;
    while (!reqReady) begin
      @(negedge clk); #1;
    end
    acc = tk;
    chk("R9", "ready in phase", memPhase, 1);
    c = acc + 1;
    cmdExp[c] = {w, a[AW-1:0]};
    if (w) begin
      wrExp[c + 2] = {d[DW-1:0], ~be[NB-1:0]};
      wrExp[c + 3] = {d[2*DW-1:DW], ~be[2*NB-1:NB]};
      for (int k = 0; k < 2; k++)
        for (int b = 0; b < NB; b++)
          if (be[k*NB + b]) shadow[2*a + k][8*b +: 8] = d[k*DW + 8*b +: 8];
    end else begin
      rspTickQ.push_back(acc + 6);
      rspDataQ.push_back({shadow[2*a + 1], shadow[2*a]});
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // memory model and response monitor, sampled mid-tick
  always @(negedge clk) begin
    if (rstN) begin
      if (!memLdN && !memPhase) begin
        if (!cmdExp.exists(tk)) chk("R11", "unexpected command", 1, 0);
        else begin
          chk("R1", "command rw/addr", {!memRw, memAddr}, cmdExp[tk]);
          cmdExp.delete(tk);
        end
        if (memRw) begin
          rdAddrAt[tk + 3] = 2 * int'(memAddr);
          rdAddrAt[tk + 4] = 2 * int'(memAddr) + 1;
        end else begin
          wrAddrAt[tk + 2] = 2 * int'(memAddr);
          wrAddrAt[tk + 3] = 2 * int'(memAddr) + 1;
        end
      end else if (cmdExp.exists(tk)) begin
        chk("R1", "missing command", 0, 1);
        cmdExp.delete(tk);
      end
      if (wrExp.exists(tk)) begin
        chk("R2", "oe in write tick", memOe, 1);
        chk("R4", "write word and lanes", {memDqOut, memBwN}, wrExp[tk]);
        if (wrAddrAt.exists(tk)) begin
          for (int b = 0; b < NB; b++)
            if (!memBwN[b]) mem[wrAddrAt[tk]][8*b +: 8] = memDqOut[8*b +: 8];
          wrAddrAt.delete(tk);
        end
        wrExp.delete(tk);
      end else if (memOe) chk("R7", "oe outside write tick", memOe, 0);
      if (rdAddrAt.exists(tk)) begin
        if (memOe) chk("R7", "bus collision", memOe, 0);
        memDqIn <= mem[rdAddrAt[tk]];
        rdAddrAt.delete(tk);
      end else begin
        memDqIn <= DW'(tk * 16'h3c5) ^ 16'h5a5a;
      end
      if (rspValid) begin
        if (rspTickQ.size() == 0) chk("R8", "unexpected response", 1, 0);
        else begin
          chk("R8", "response tick", tk, rspTickQ.pop_front());
          chk("R5", "response words", rspData, rspDataQ.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int aR, aW, a1, a2;
    logic [31:0] seed;
    for (int i = 0; i < WORDS; i++) begin
      mem[i] = DW'(i * 16'h1357) ^ 16'h2468;
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    #1;
    chk("R10", "ldN in reset", memLdN, 1);
    chk("R10", "oe in reset", memOe, 0);
    chk("R10", "rspValid in reset", rspValid, 0);
    chk("R10", "ready in reset", reqReady, 0);
    chk("R10", "phase in reset", memPhase, 0);
    @(negedge clk);
    rstN = 1'b1;
    #1 chk("R10", "phase first tick", memPhase, 0);
    @(negedge clk);
    #1 chk("R10", "phase toggles", memPhase, 1);
    @(negedge clk);

    // full write then read back (read after write: gap 2)
    issue(1, 5, 32'hcafe_beef, 4'b1111, aW);
    issue(0, 5, '0, '0, aR);
    chk("R6", "read after write gap", aR - aW, 2);
    // partial byte enables (R4)
    issue(1, 5, 32'h1122_3344, 4'b0110, aW);
    issue(0, 5, '0, '0, aR);
    // back-to-back reads (R3)
    issue(0, 7, '0, '0, a1);
    issue(0, 8, '0, '0, a2);
    chk("R3", "read after read gap", a2 - a1, 2);
    issue(0, 9, '0, '0, a1);
    // read then write on same address: turnaround stall (R6)
    issue(0, 12, '0, '0, aR);
    #1 chk("R6", "ready held for write after read", reqReady, 0);
    issue(1, 12, 32'ha5a5_0f0f, 4'b1011, aW);
    chk("R6", "write after read gap", aW - aR, 4);
    issue(0, 12, '0, '0, aR);
    // back-to-back writes
    issue(1, 20, 32'h0102_0304, 4'b1111, a1);
    issue(1, 21, 32'h0506_0708, 4'b0101, a2);
    chk("R2", "write after write gap", a2 - a1, 2);
    issue(0, 20, '0, '0, a1);
    issue(0, 21, '0, '0, a1);
    // idle slot (R11)
    repeat (12) @(negedge clk);
    #1 chk("R11", "idle ldN", memLdN, 1);
    @(negedge clk);
    // mixed traffic on a small address window
    seed = 32'h1234_5678;
    for (int n = 0; n < 60; n++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      issue(seed[31], int'(seed[11:8]), {seed[15:0], seed[31:16]} ^ 32'h9e37_79b9,
            seed[23:20] | 4'b0001, a1);
      if (seed[5:3] == 3'd0) repeat (2) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    chk("R8", "all responses returned", rspTickQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule